// File: doc/BRIEF.md
# DAC Channel Trigger Select and Transfer Unit

This block decides when a 12-bit held sample is copied into the output data register of one converter channel. Software writes samples into a held register. When triggering is off, each write moves to the output after one clock. When triggering is on, the copy happens on a trigger event instead. The event is either a software request or a rising edge on one of fifteen external trigger lines, chosen by a 4-bit selector.

Hardware-triggered copies take three clocks from the sampled edge. Software-requested copies take one clock. Every triggered copy raises a one-cycle step strobe in the same cycle as the output update, so a wave generator can advance. A channel enable gates all activity.

Top module: `dac_xfer_ctrl`

## Requirements
- R1: With `chan_en`=1 and `trig_en`=0, a write sampled at clock edge t updates `held`, and `dout` shows the written value after edge t+1. No step strobe is raised.
- R2: With `chan_en`=1, `trig_en`=1 and a nonzero selector, a rising edge on the selected line, first sampled high at edge e, loads `dout` from the held register at edge e+3.
- R3: Selector code 0 picks the software request. A `sw_trig_set` pulse sampled at edge t loads `dout` at edge t+1 when `chan_en`=1, `trig_en`=1 and `trig_sel`=0. A request raised under another selector stays pending and is served one edge after the selector returns to 0.
- R4: Selector code k in 1..15 picks `ext_trig[k-1]`. Edges on the other lines have no effect.
- R5: With `trig_en`=0, the external lines and the selector have no effect on `dout` or `step_strobe`.
- R6: A line held high for several cycles causes exactly one transfer. Only the 0-to-1 transition counts.
- R7: `sw_pend` reads 1 from the edge that samples `sw_trig_set` until the edge that performs its transfer, where it clears.
- R8: While `chan_en`=0, `dout` keeps its value and `step_strobe` stays 0. Pending hardware transfers and software requests are discarded, and `sw_trig_set` is ignored. Writes still update the held register.
- R9: `step_strobe` is high for one cycle per triggered transfer, in the cycle in which the new `dout` value first appears.
- R10: A selected edge that arrives while a three-cycle transfer is running is captured. Its transfer completes three edges after the running one.
- R11: With `trig_en`=1, writes only change the held register. A triggered transfer copies the held value present at the transfer edge.
- R12: After synchronous reset, `dout`=0, `sw_pend`=0 and `step_strobe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 1 | Channel enable |
| trig_en | input | 1 | Trigger mode enable |
| trig_sel | input | 4 | Trigger source: 0 software, k external line k-1 |
| wr_valid | input | 1 | Write strobe for the held register |
| wr_data | input | 12 | Sample to hold |
| sw_trig_set | input | 1 | Software trigger request pulse |
| ext_trig | input | 15 | External trigger lines |
| dout | output | 12 | Output data register |
| sw_pend | output | 1 | Software request pending |
| step_strobe | output | 1 | One-cycle pulse per triggered transfer |

## Verification
The hardest case to reach is a second selected edge landing while the three-cycle transfer is still counting down. The stimulus pulses the selected line twice, two cycles apart, and rewrites the held register between the first transfer and the queued one. This shows that the queued copy runs afterwards and reads fresh data.

Two other cases need care in the stimulus. Dropping the channel enable one cycle after an edge checks that the in-flight transfer is cancelled. Parking a software request under a nonzero selector checks that it waits, and is served once the selector returns to zero.

// File: rtl/dac_xfer_pkg.sv
package dac_xfer_pkg;
  localparam int unsigned DEF_DW     = 12;
  localparam int unsigned DEF_SEL_W  = 4;
  localparam int unsigned DEF_HW_LAT = 3;

  typedef enum logic [1:0] {
    XF_NONE   = 2'd0,
    XF_DIRECT = 2'd1,
    XF_TRIG   = 2'd2
  } xfer_kind_t;
endpackage

// File: rtl/trig_edge_sel.sv
module trig_edge_sel #(
  parameter int unsigned SEL_W   = 4,
  parameter int unsigned NUM_EXT = (1 << SEL_W) - 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EXT-1:0] ext_trig,
  input  logic [SEL_W-1:0]   sel,
  output logic               hw_event
);
  localparam int unsigned SLOTS = 1 << SEL_W;

  logic [NUM_EXT-1:0] prev_q;
  logic [NUM_EXT-1:0] rise;
  logic [SLOTS-1:0]   rise_slot;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= ext_trig;
  end

  // slot 0 is the software source, never a hardware event
  assign rise_slot[0] = 1'b0;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_EXT; gi++) begin : g_line
      assign rise[gi]        = ext_trig[gi] & ~prev_q[gi];
      assign rise_slot[gi+1] = rise[gi];
    end
    for (gi = NUM_EXT + 1; gi < SLOTS; gi++) begin : g_pad
      assign rise_slot[gi] = 1'b0;
    end
  endgenerate

  assign hw_event = rise_slot[sel];
endmodule

// File: rtl/hw_xfer_seq.sv
module hw_xfer_seq #(
  parameter int unsigned LAT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic start,
  output logic fire,
  output logic busy
);
  localparam int unsigned CW = (LAT > 2) ? $clog2(LAT) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(LAT - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic          queued_q;

  assign fire = busy_q && (cnt_q == '0);
  assign busy = busy_q;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      busy_q   <= 1'b0;
      queued_q <= 1'b0;
      cnt_q    <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= RELOAD;
      end
    end else if (fire) begin
      if (queued_q || start) begin
        cnt_q    <= RELOAD;
        queued_q <= 1'b0;
      end else begin
        busy_q <= 1'b0;
      end
    end else begin
      cnt_q <= cnt_q - 1'b1;
      if (start) queued_q <= 1'b1;
    end
  end
endmodule

// File: rtl/dac_xfer_ctrl.sv
module dac_xfer_ctrl
  import dac_xfer_pkg::*;
#(
  parameter int unsigned DW     = DEF_DW,
  parameter int unsigned SEL_W  = DEF_SEL_W,
  parameter int unsigned HW_LAT = DEF_HW_LAT,
  localparam int unsigned NUM_EXT = (1 << SEL_W) - 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               chan_en,
  input  logic               trig_en,
  input  logic [SEL_W-1:0]   trig_sel,
  input  logic               wr_valid,
  input  logic [DW-1:0]      wr_data,
  input  logic               sw_trig_set,
  input  logic [NUM_EXT-1:0] ext_trig,
  output logic [DW-1:0]      dout,
  output logic               sw_pend,
  output logic               step_strobe
);
  logic [DW-1:0] held_q;
  logic          direct_q;
  logic          sw_q;
  logic          hw_event;
  logic          hw_fire;
  logic          hw_busy;
  logic          trig_on;
  logic          sw_go;
  xfer_kind_t    kind;

  assign trig_on = chan_en && trig_en;
  assign sw_go   = trig_on && (trig_sel == '0) && sw_q;

  trig_edge_sel #(.SEL_W(SEL_W), .NUM_EXT(NUM_EXT)) u_edge (
    .clk      (clk),
    .rst      (rst),
    .ext_trig (ext_trig),
    .sel      (trig_sel),
    .hw_event (hw_event)
  );

  hw_xfer_seq #(.LAT(HW_LAT)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .enable (chan_en),
    .start  (trig_on && hw_event),
    .fire   (hw_fire),
    .busy   (hw_busy)
  );

  always_comb begin
    if (!chan_en)             kind = XF_NONE;
    else if (hw_fire || sw_go) kind = XF_TRIG;
    else if (direct_q)        kind = XF_DIRECT;
    else                      kind = XF_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q      <= '0;
      direct_q    <= 1'b0;
      sw_q        <= 1'b0;
      dout        <= '0;
      step_strobe <= 1'b0;
    end else begin
      if (wr_valid) held_q <= wr_data;
      direct_q    <= wr_valid && chan_en && !trig_en;
      step_strobe <= (kind == XF_TRIG);
      if (kind != XF_NONE) dout <= held_q;
      if (!chan_en)         sw_q <= 1'b0;
      else if (sw_trig_set) sw_q <= 1'b1;
      else if (sw_go)       sw_q <= 1'b0;
    end
  end

  assign sw_pend = sw_q;
endmodule

// File: rtl/dac_xfer_ctrl_chk.sv
module dac_xfer_ctrl_chk #(
  parameter int unsigned DW      = 12,
  parameter int unsigned SEL_W   = 4,
  parameter int unsigned NUM_EXT = 15
) (
  input logic               clk,
  input logic               rst,
  input logic               chan_en,
  input logic               trig_en,
  input logic [SEL_W-1:0]   trig_sel,
  input logic               wr_valid,
  input logic [DW-1:0]      wr_data,
  input logic               sw_trig_set,
  input logic [NUM_EXT-1:0] ext_trig,
  input logic [DW-1:0]      dout,
  input logic               sw_pend,
  input logic               step_strobe
);
  a_r8_disabled_holds: assert property (@(posedge clk) disable iff (rst)
    !chan_en |=> ($stable(dout) && !step_strobe));

  a_r8_request_dropped: assert property (@(posedge clk) disable iff (rst)
    !chan_en |=> !sw_pend);

  a_r1_direct_copy: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && chan_en && !trig_en) ##1 chan_en |=> (dout == $past(wr_data, 2)));

  a_r3_sw_transfer: assert property (@(posedge clk) disable iff (rst)
    (sw_pend && chan_en && trig_en && (trig_sel == '0)) |=> step_strobe);

  a_r7_sw_self_clear: assert property (@(posedge clk) disable iff (rst)
    (sw_pend && chan_en && trig_en && (trig_sel == '0) && !sw_trig_set) |=> !sw_pend);

  a_r7_sw_raise: assert property (@(posedge clk) disable iff (rst)
    (sw_trig_set && chan_en) |=> sw_pend);
endmodule

bind dac_xfer_ctrl dac_xfer_ctrl_chk #(.DW(DW), .SEL_W(SEL_W), .NUM_EXT(NUM_EXT)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .chan_en     (chan_en),
  .trig_en     (trig_en),
  .trig_sel    (trig_sel),
  .wr_valid    (wr_valid),
  .wr_data     (wr_data),
  .sw_trig_set (sw_trig_set),
  .ext_trig    (ext_trig),
  .dout        (dout),
  .sw_pend     (sw_pend),
  .step_strobe (step_strobe)
);

// File: tb/tb_dac_xfer_ctrl.sv
module tb_dac_xfer_ctrl;
  localparam int DW = 12;
  localparam int SW = 4;
  localparam int NE = 15;

  typedef struct {
    int          cyc;
    logic [11:0] data;
    logic        stb;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          chan_en = 1'b0, trig_en = 1'b0;
  logic [SW-1:0] trig_sel = '0;
  logic          wr_valid = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          sw_trig_set = 1'b0;
  logic [NE-1:0] ext_trig = '0;
  logic [DW-1:0] dout;
  logic          sw_pend, step_strobe;

  int   cyc = 0;
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;
  exp_t q[$];
  logic [DW-1:0] m_held = '0, m_dout = '0;

  always #10 clk = ~clk;

  dac_xfer_ctrl dut (
    .clk(clk), .rst(rst), .chan_en(chan_en), .trig_en(trig_en), .trig_sel(trig_sel),
    .wr_valid(wr_valid), .wr_data(wr_data), .sw_trig_set(sw_trig_set), .ext_trig(ext_trig),
    .dout(dout), .sw_pend(sw_pend), .step_strobe(step_strobe)
  );

  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor: pops scoreboard entries on their due cycle, otherwise expects no change
  always @(negedge clk) begin
    if (!rst) begin
      if (q.size() > 0 && q[0].cyc < cyc) begin
        chk(1'b0, "R9 missed transfer", int'(dout), int'(q[0].data));
        void'(q.pop_front());
      end
      if (q.size() > 0 && q[0].cyc == cyc) begin
        chk(dout == q[0].data, "R1/R2/R3 dout", int'(dout), int'(q[0].data));
        chk(step_strobe == q[0].stb, "R9 strobe", int'(step_strobe), int'(q[0].stb));
        m_dout = q[0].data;
        void'(q.pop_front());
      end else begin
        chk(step_strobe == 1'b0, "R5/R8 stray strobe", int'(step_strobe), 0);
        chk(dout == m_dout, "R5/R8 dout hold", int'(dout), int'(m_dout));
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [DW-1:0] d);
    wr_valid = 1'b1; wr_data = d;
    if (chan_en && !trig_en) q.push_back('{cyc + 2, d, 1'b0}); // R1
    m_held = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic pulse(input int idx, input bit expect_xfer);
    ext_trig[idx] = 1'b1;
    if (expect_xfer) q.push_back('{cyc + 4, m_held, 1'b1}); // R2
    @(negedge clk);
    ext_trig[idx] = 1'b0;
  endtask

  initial begin
    idle(3);
    chk(dout == '0, "R12 dout", int'(dout), 0);
    chk(sw_pend == 1'b0, "R12 sw_pend", int'(sw_pend), 0);
    chk(step_strobe == 1'b0, "R12 strobe", int'(step_strobe), 0);
    rst = 1'b0;
    chan_en = 1'b1;
    idle(2);

    // R1: untriggered writes, including back-to-back
    wr(12'h5A5); idle(3);
    wr(12'hFFF); wr(12'h001); wr(12'h800); idle(3);

    // R8: disabled channel
    chan_en = 1'b0;
    wr(12'h123); idle(2);
    sw_trig_set = 1'b1; @(negedge clk); sw_trig_set = 1'b0;
    chk(sw_pend == 1'b0, "R8 sw request ignored", int'(sw_pend), 0);
    pulse(0, 1'b0); idle(4);
    chan_en = 1'b1; idle(2);

    // R11 + R3 + R7: trigger mode, software source
    trig_en = 1'b1; trig_sel = 4'd0;
    wr(12'h3C3); idle(3);
    chk(sw_pend == 1'b0, "R7 idle pend", int'(sw_pend), 0);
    sw_trig_set = 1'b1;
    q.push_back('{cyc + 2, m_held, 1'b1});
    @(negedge clk); sw_trig_set = 1'b0;
    chk(sw_pend == 1'b1, "R7 pend raised", int'(sw_pend), 1);
    @(negedge clk);
    chk(sw_pend == 1'b0, "R7 pend cleared", int'(sw_pend), 0);
    idle(2);

    // R3: request parked under a hardware selector
    trig_sel = 4'd5;
    wr(12'h0AB);
    sw_trig_set = 1'b1; @(negedge clk); sw_trig_set = 1'b0;
    idle(3);
    chk(sw_pend == 1'b1, "R3 parked request", int'(sw_pend), 1);
    trig_sel = 4'd0;
    q.push_back('{cyc + 1, m_held, 1'b1});
    idle(2);
    chk(sw_pend == 1'b0, "R3 parked served", int'(sw_pend), 0);

    // R2 + R4: hardware selector 5 -> line 4
    trig_sel = 4'd5;
    wr(12'h456); idle(2);
    pulse(4, 1'b1); idle(5);
    pulse(3, 1'b0); pulse(5, 1'b0); idle(5);

    // R6: line held high gives one transfer
    ext_trig[4] = 1'b1;
    q.push_back('{cyc + 4, m_held, 1'b1});
    idle(7);
    ext_trig[4] = 1'b0; idle(5);

    // R10: second edge while busy, held rewritten in between
    begin
      int c0;
      c0 = cyc;
      ext_trig[4] = 1'b1; q.push_back('{c0 + 4, m_held, 1'b1});
      @(negedge clk); ext_trig[4] = 1'b0;
      @(negedge clk); ext_trig[4] = 1'b1;
      @(negedge clk); ext_trig[4] = 1'b0;
      @(negedge clk);
      wr(12'h9E7); // held updates at edge c0+5
      q.push_back('{c0 + 7, 12'h9E7, 1'b1});
      idle(6);
    end

    // R4: extreme selector codes
    trig_sel = 4'd15; pulse(14, 1'b1); idle(5);
    trig_sel = 4'd1;  pulse(0, 1'b1);  pulse(14, 1'b0); idle(5);

    // R8: disable cancels an in-flight transfer
    pulse(0, 1'b0);
    chan_en = 1'b0; idle(5);
    chan_en = 1'b1; idle(3);

    // R5: trigger mode off, external edges ignored, writes go straight through
    trig_en = 1'b0; trig_sel = 4'd5;
    pulse(4, 1'b0); idle(5);
    wr(12'h777); idle(4);

    chk(q.size() == 0, "R9 scoreboard drained", q.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected 0 hung cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule